// File: doc/BRIEF.md
# Four-Lane Floating-Point Compare, Min/Max and Mask-Select Unit

This unit takes two 128-bit operands, each made of four 32-bit single-precision lanes, and produces one 128-bit result per accepted request. It can run a lane-wise comparison under one of eight predicates, giving a whole-lane mask of all ones or all zeros. It can also return the lane-wise minimum or maximum, or combine the operands with bitwise AND, AND-NOT or OR. Lane 0 occupies bits 31:0 and lane 3 occupies bits 127:96.

Compare masks and the three bitwise operations together give branch-free selection. A compare builds a mask, and the result is then formed as (mask AND c) OR (NOT mask AND d). A scalar mode computes only lane 0. In that mode the upper three lanes of the result are copied from the first operand, which plays the role of the destination. The unit has no arithmetic, rounding or exception flags. Ordering follows sign and magnitude, with special handling for signed zeros, infinities and NaN.

Top module: `qcs_top`

## Requirements
- R1: `op` 0 is a compare. Each computed lane is all ones when predicate `pred` holds and all zeros when it does not. The `pred` codes are 0 equal, 1 less, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less, 6 not-less-or-equal, 7 ordered.
- R2: Lane ordering follows sign and magnitude. Larger negative magnitudes are smaller, +0 and -0 compare equal, -inf is below every finite value and +inf equals +inf.
- R3: A lane holds a NaN when its exponent field is all ones and its mantissa is non-zero. When either input of a lane is a NaN, predicates 0, 1, 2 and 7 are false and predicates 3, 4, 5 and 6 are true.
- R4: `op` 1 (min) returns the first operand's lane when it is strictly less than the second, and otherwise returns the second operand's lane. This covers equal values, signed zeros and NaN.
- R5: `op` 2 (max) returns the first operand's lane when it is strictly greater than the second, and otherwise returns the second operand's lane.
- R6: `op` 3 gives a AND b, `op` 4 gives (NOT a) AND b, and `op` 5 gives a OR b, all bitwise.
- R7: With `scalar` high, only lane 0 is computed and result bits 127:32 equal `src_a` bits 127:32. With `scalar` low, all four lanes are computed.
- R8: `op` codes 6 and 7 are reserved and produce zero in every computed lane.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `result` changes only on an accepted request and holds its value otherwise.
- R10: While `rst` is high, and in the cycle after it, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation select |
| pred | input | 3 | Compare predicate |
| scalar | input | 1 | 1 = lane 0 only, 0 = all lanes |
| src_a | input | 128 | First operand / destination lanes |
| src_b | input | 128 | Second operand |
| out_valid | output | 1 | Result registered from last request |
| result | output | 128 | Registered result |

## Verification
The assertions assume that `op`, `pred`, `scalar` and both operands are known and stable around the rising edge whenever `in_valid` is high. They also assume that reset is held for at least one edge before the first request. The bench meets both conditions by driving every input on the falling edge and by raising `in_valid` only after reset has been released. The properties that check lane selection (min picks an operand, masks are whole lanes, scalar upper lanes pass through) rely on that stability, because they compare the result with the operands one cycle earlier.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
    localparam int LANE_W = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = LANE_W - EXP_W - 1;

    typedef enum logic [2:0] {
        OP_CMP  = 3'd0,
        OP_MIN  = 3'd1,
        OP_MAX  = 3'd2,
        OP_AND  = 3'd3,
        OP_ANDN = 3'd4,
        OP_OR   = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_UNORD = 3'd3,
        PR_NEQ   = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_ORD   = 3'd7
    } pred_e;

    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
        logic gt;
    } rel_t;

    function automatic logic is_nan(input logic [LANE_W-1:0] x);
        return (&x[LANE_W-2:MAN_W]) && (|x[MAN_W-1:0]);
    endfunction

    // Monotone unsigned key: negatives inverted, positives offset above them
    function automatic logic [LANE_W-1:0] order_key(input logic [LANE_W-1:0] x);
        return x[LANE_W-1] ? ~x : {1'b1, x[LANE_W-2:0]};
    endfunction
endpackage

// File: rtl/qcs_lane_cmp.sv
module qcs_lane_cmp
    import qcs_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output rel_t              rel
);
    logic              both_zero;
    logic [LANE_W-1:0] ka;
    logic [LANE_W-1:0] kb;

    always_comb begin
        both_zero = (a[LANE_W-2:0] == '0) && (b[LANE_W-2:0] == '0);
        ka        = order_key(a);
        kb        = order_key(b);
        rel.unord = is_nan(a) || is_nan(b);
        rel.eq    = !rel.unord && (both_zero || (a == b));
        rel.lt    = !rel.unord && !both_zero && (ka < kb);
        rel.gt    = !rel.unord && !rel.eq && !rel.lt;
    end
endmodule

// File: rtl/qcs_lane_op.sv
module qcs_lane_op
    import qcs_pkg::*;
(
    input  op_e               op,
    input  pred_e             pred,
    input  rel_t              rel,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] y
);
    logic hit;

    always_comb begin
        unique case (pred)
            PR_EQ:    hit = rel.eq;
            PR_LT:    hit = rel.lt;
            PR_LE:    hit = rel.lt || rel.eq;
            PR_UNORD: hit = rel.unord;
            PR_NEQ:   hit = !rel.eq;
            PR_NLT:   hit = !rel.lt;
            PR_NLE:   hit = !(rel.lt || rel.eq);
            default:  hit = !rel.unord;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_CMP:  y = {LANE_W{hit}};
            OP_MIN:  y = rel.lt ? a : b;
            OP_MAX:  y = rel.gt ? a : b;
            OP_AND:  y = a & b;
            OP_ANDN: y = ~a & b;
            OP_OR:   y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/qcs_top.sv
module qcs_top
    import qcs_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic [2:0]       pred,
    input  logic             scalar,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    op_e              op_q;
    pred_e            pred_q;
    logic [VEC_W-1:0] lane_y;
    logic [VEC_W-1:0] next_res;

    assign op_q   = op_e'(op);
    assign pred_q = pred_e'(pred);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rel_t rel;
        qcs_lane_cmp u_cmp (
            .a   (src_a[g*LANE_W +: LANE_W]),
            .b   (src_b[g*LANE_W +: LANE_W]),
            .rel (rel)
        );
        qcs_lane_op u_op (
            .op   (op_q),
            .pred (pred_q),
            .rel  (rel),
            .a    (src_a[g*LANE_W +: LANE_W]),
            .b    (src_b[g*LANE_W +: LANE_W]),
            .y    (lane_y[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        next_res = lane_y;
        if (scalar)
            next_res[VEC_W-1:LANE_W] = src_a[VEC_W-1:LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= next_res;
        end
    end
endmodule

// File: rtl/qcs_checker.sv
module qcs_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       op,
    input logic [2:0]       pred,
    input logic             scalar,
    input logic [VEC_W-1:0] src_a,
    input logic [VEC_W-1:0] src_b,
    input logic             out_valid,
    input logic [VEC_W-1:0] result
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    a_r7_upper_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scalar) |=> result[VEC_W-1:32] == $past(src_a[VEC_W-1:32]));

    a_r1_mask_whole: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0) |=>
            (result[31:0] == 32'h0 || result[31:0] == 32'hFFFF_FFFF));

    a_r4_min_picks_operand: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd1) |=>
            (result[31:0] == $past(src_a[31:0]) || result[31:0] == $past(src_b[31:0])));

    a_r5_max_picks_operand: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd2) |=>
            (result[31:0] == $past(src_a[31:0]) || result[31:0] == $past(src_b[31:0])));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[2:1] == 2'b11 && !scalar) |=> result == '0);
endmodule

bind qcs_top qcs_checker #(.VEC_W(VEC_W)) u_qcs_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .pred      (pred),
    .scalar    (scalar),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/qcs_top_bench.sv
module qcs_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    typedef struct packed {
        logic [2:0]   op;
        logic [2:0]   pred;
        logic         scal;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
        logic [3:0]   req;
    } vec_t;

    // Lanes written {lane3, lane2, lane1, lane0}
    localparam logic [127:0] A_MIX = {32'h3F80_0000, 32'hC000_0000, 32'h0000_0000, 32'h7FC0_0000};
    localparam logic [127:0] B_MIX = {32'h4000_0000, 32'hBF80_0000, 32'h8000_0000, 32'h3F80_0000};
    localparam logic [127:0] A_BIT = 128'hF0F0F0F0_FFFFFFFF_00000000_12345678;
    localparam logic [127:0] B_BIT = 128'hFF00FF00_0F0F0F0F_FFFFFFFF_FFFF0000;
    localparam logic [127:0] ONES  = 32'hFFFF_FFFF;

    localparam vec_t VECS [NV] = '{
        // R1 R2 R3: less-than over mixed lanes (1<2, -2<-1, +0 vs -0, NaN)
        '{3'd0, 3'd1, 1'b0, A_MIX, B_MIX, {ONES[31:0], ONES[31:0], 32'h0, 32'h0}, 4'd1},
        // R1 R2: equal, signed zeros equal
        '{3'd0, 3'd0, 1'b0, A_MIX, B_MIX, {32'h0, 32'h0, ONES[31:0], 32'h0}, 4'd1},
        '{3'd0, 3'd2, 1'b0, A_MIX, B_MIX, {ONES[31:0], ONES[31:0], ONES[31:0], 32'h0}, 4'd1},
        // R3: unordered
        '{3'd0, 3'd3, 1'b0, A_MIX, B_MIX, {32'h0, 32'h0, 32'h0, ONES[31:0]}, 4'd3},
        '{3'd0, 3'd4, 1'b0, A_MIX, B_MIX, {ONES[31:0], ONES[31:0], 32'h0, ONES[31:0]}, 4'd3},
        '{3'd0, 3'd5, 1'b0, A_MIX, B_MIX, {32'h0, 32'h0, ONES[31:0], ONES[31:0]}, 4'd3},
        '{3'd0, 3'd6, 1'b0, A_MIX, B_MIX, {32'h0, 32'h0, 32'h0, ONES[31:0]}, 4'd3},
        '{3'd0, 3'd7, 1'b0, A_MIX, B_MIX, {ONES[31:0], ONES[31:0], ONES[31:0], 32'h0}, 4'd1},
        // R2: -2<-1, -tiny<+tiny, inf<inf false, -inf<max finite
        '{3'd0, 3'd1, 1'b0,
          {32'hC000_0000, 32'h8000_0001, 32'h7F80_0000, 32'hFF80_0000},
          {32'hBF80_0000, 32'h0000_0001, 32'h7F80_0000, 32'h7F7F_FFFF},
          {ONES[31:0], ONES[31:0], 32'h0, ONES[31:0]}, 4'd2},
        // R4: min, signed-zero tie and NaN give b
        '{3'd1, 3'd0, 1'b0, A_MIX, B_MIX, {32'h3F80_0000, 32'hC000_0000, 32'h8000_0000, 32'h3F80_0000}, 4'd4},
        // R5: max
        '{3'd2, 3'd0, 1'b0, A_MIX, B_MIX, {32'h4000_0000, 32'hBF80_0000, 32'h8000_0000, 32'h3F80_0000}, 4'd5},
        // R4: clamp with infinities
        '{3'd1, 3'd0, 1'b0,
          {32'h7F80_0000, 32'hFF80_0000, 32'h3F00_0000, 32'hBF80_0000},
          {32'h3F80_0000, 32'h3F80_0000, 32'h7F80_0000, 32'hFF80_0000},
          {32'h3F80_0000, 32'hFF80_0000, 32'h3F00_0000, 32'hFF80_0000}, 4'd4},
        // R7: scalar min, upper lanes from a
        '{3'd1, 3'd0, 1'b1, 128'h11111111_22222222_33333333_40000000,
          128'h44444444_55555555_66666666_3F800000,
          128'h11111111_22222222_33333333_3F800000, 4'd7},
        // R7: scalar compare -1 < +0
        '{3'd0, 3'd1, 1'b1, 128'h11111111_22222222_33333333_BF800000,
          128'h44444444_55555555_66666666_00000000,
          128'h11111111_22222222_33333333_FFFFFFFF, 4'd7},
        // R6: AND, AND-NOT, OR
        '{3'd3, 3'd0, 1'b0, A_BIT, B_BIT, 128'hF000F000_0F0F0F0F_00000000_12340000, 4'd6},
        '{3'd4, 3'd0, 1'b0, A_BIT, B_BIT, 128'h0F000F00_00000000_FFFFFFFF_EDCB0000, 4'd6},
        '{3'd5, 3'd0, 1'b0, A_BIT, B_BIT, 128'hFFF0FFF0_FFFFFFFF_FFFFFFFF_FFFF5678, 4'd6},
        // R8: reserved op
        '{3'd6, 3'd0, 1'b0, A_BIT, B_BIT, 128'h0, 4'd8}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [2:0]   op;
    logic [2:0]   pred;
    logic         scalar;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic         out_valid;
    logic [127:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qcs_top u_qcs_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pred(pred),
        .scalar(scalar), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge; sample at the next falling edge
    task automatic issue(input logic [2:0] o, input logic [2:0] p, input logic s,
                         input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = o; pred = p; scalar = s; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [127:0] mask;
        logic [127:0] keep;
        logic [127:0] held;
        rst = 1'b1; in_valid = 1'b0; op = '0; pred = '0; scalar = 1'b0;
        src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        check("R10 reset out_valid", {127'b0, out_valid}, 128'h0);
        check("R10 reset result", result, 128'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].pred, VECS[i].scal, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
            check("R9 out_valid after request", {127'b0, out_valid}, 128'h1);
        end

        // R9: idle cycle with changed inputs keeps result, drops out_valid
        held = result;
        op = 3'd5; src_a = '1; src_b = '1;
        @(negedge clk);
        check("R9 idle out_valid low", {127'b0, out_valid}, 128'h0);
        check("R9 idle result held", result, held);

        // R1 R6: branch-free select (a<b) ? c : d per lane
        issue(3'd0, 3'd1, 1'b0, A_MIX, B_MIX);
        mask = result;
        issue(3'd3, 3'd0, 1'b0, mask, 128'hC3C3C3C3_C2C2C2C2_C1C1C1C1_C0C0C0C0);
        keep = result;
        issue(3'd4, 3'd0, 1'b0, mask, 128'hD3D3D3D3_D2D2D2D2_D1D1D1D1_D0D0D0D0);
        issue(3'd5, 3'd0, 1'b0, keep, result);
        check("R6 select result", result, 128'hC3C3C3C3_C2C2C2C2_D1D1D1D1_D0D0D0D0);

        // R8: reserved op 7 in scalar mode zeroes lane 0, upper from a (R7)
        issue(3'd7, 3'd0, 1'b1, A_BIT, B_BIT);
        check("R8 scalar reserved", result, {A_BIT[127:32], 32'h0});

        // R10: reset mid-run clears result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset clears result", result, 128'h0);
        check("R10 reset clears out_valid", {127'b0, out_valid}, 128'h0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule